// File: doc/BRIEF.md
# Cache Range Maintenance Engine

This block turns a pair of register writes into a sequence of per-line cache maintenance commands. Software first writes a start address to a range-start register, then writes an inclusive end address to the matching range-end register. The end write launches a walk over every cache line whose first byte lies between the two addresses. The walk runs in ascending order, one line per accepted command, and the engine issues either clean or invalidate commands, depending on which register pair was written. Single-line clean, invalidate and clean-plus-invalidate commands can also be issued by address through the same write port.

Only the start address has been translated. The page number of every command therefore comes from the start address, and the page bits of the end address are discarded. While a walk is running, the engine holds `stall` high so that the requester stays blocked. It pulses `done` once the last command has been taken.

The command output is a valid/ready stream. The engine raises `cmd_valid` with `cmd_op` and `cmd_addr`. It keeps all three unchanged until it samples `cmd_ready` high on a clock edge, and only then moves on to the next line. The cache model may hold `cmd_ready` low for any number of cycles. The register write port has no handshake. Writes that arrive while `stall` is high are dropped.

Top module: `range_maint_engine`

## Requirements
- R1: After reset, `stall`, `done` and `cmd_valid` are low.
- R2: The `reg_sel` codes are: 3 = clean-range start, 4 = clean-range end, 5 = invalidate-range start, 6 = invalidate-range end. An end write that follows a start write of the same kind launches a walk. The walk issues one command per line in ascending order, and each address is 32 bytes above the previous one. `cmd_op` is 0 for a clean range and 1 for an invalidate range.
- R3: The first line of a walk is the lowest 32-byte-aligned address that is not below the start address. The last line is the highest aligned address that is not above the end address. Both bounds are inclusive.
- R4: If the first line lies above the last line, no command is issued, `stall` stays low, and `done` pulses in the cycle after the end write.
- R5: `stall` and `cmd_valid` rise in the cycle after the launching write and stay high until the final command has been accepted.
- R6: While `cmd_valid` is high and `cmd_ready` is low, `cmd_addr` and `cmd_op` hold their values.
- R7: `done` is high for exactly one cycle, namely the cycle after the final command is accepted, and `stall` is low in that cycle.
- R8: A start write that arrives before the end write replaces the pending start address and the pending kind.
- R9: An end write is ignored if no start is pending, or if the pending start is of the other kind. In the second case the pending start is kept.
- R10: Every command of a walk carries the page number (address bits above bit 11, with 4 KiB pages) of the start address. The page bits of the end address are ignored.
- R11: `reg_sel` codes 0, 1 and 2 each issue a single command at the address rounded down to 32 bytes. The `cmd_op` is 0 (clean), 1 (invalidate) or 2 (clean and invalidate) respectively, and the command ends with a `done` pulse.
- R12: Register writes made while `stall` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register / command select code |
| reg_wdata | input | ADDR_W | Write data (address) |
| stall | output | 1 | Requester blocked while a walk runs |
| done | output | 1 | One-cycle completion pulse |
| cmd_valid | output | 1 | Line command valid |
| cmd_ready | input | 1 | Cache model accepts the command |
| cmd_op | output | 2 | 0 clean, 1 invalidate, 2 clean and invalidate |
| cmd_addr | output | ADDR_W | Line-aligned command address |

## Verification
The hardest condition to reach from the ports is a register write that arrives in the middle of a walk. The requester is supposed to be blocked, so a well-behaved bench never produces one. The stimulus therefore launches a walk, holds `cmd_ready` low to freeze it, and writes line and range registers while `stall` is high. It then releases the walk and confirms that only the original lines appear. Empty ranges, an unaligned start that rounds past an aligned end, and an end in a foreign page are driven through the same vector table as the normal walks.

// File: rtl/rme_pkg.sv
package rme_pkg;
  typedef enum logic [1:0] {
    OP_CLEAN     = 2'd0,
    OP_INV       = 2'd1,
    OP_CLEAN_INV = 2'd2
  } line_op_e;

  typedef enum logic [2:0] {
    SEL_LINE_CLEAN  = 3'd0,
    SEL_LINE_INV    = 3'd1,
    SEL_LINE_CLINV  = 3'd2,
    SEL_CLEAN_START = 3'd3,
    SEL_CLEAN_END   = 3'd4,
    SEL_INV_START   = 3'd5,
    SEL_INV_END     = 3'd6,
    SEL_NONE        = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/rme_regcap.sv
module rme_regcap
  import rme_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 5,
  parameter int PAGE_W = 12,
  localparam int IDX_W = PAGE_W - LINE_W,
  localparam int PG_W  = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              busy,
  output logic              launch,
  output line_op_e          launch_op,
  output logic [PG_W-1:0]   launch_page,
  output logic [IDX_W:0]    launch_first,
  output logic [IDX_W-1:0]  launch_last
);
  logic              pend_vld;
  logic              pend_inv;
  logic [ADDR_W-1:0] pend_addr;
  logic              accept;
  logic              end_hit;
  logic [IDX_W:0]    pend_first;

  assign accept = wr_en && !busy;

  // Round the pending start up to the next line boundary.
  assign pend_first = {1'b0, pend_addr[PAGE_W-1:LINE_W]}
                    + {{IDX_W{1'b0}}, |pend_addr[LINE_W-1:0]};

  always_comb begin
    launch       = 1'b0;
    end_hit      = 1'b0;
    launch_op    = OP_CLEAN;
    launch_page  = wr_data[ADDR_W-1:PAGE_W];
    launch_first = {1'b0, wr_data[PAGE_W-1:LINE_W]};
    launch_last  = wr_data[PAGE_W-1:LINE_W];
    unique case (reg_sel_e'(wr_sel))
      SEL_LINE_CLEAN: begin launch = accept; launch_op = OP_CLEAN;     end
      SEL_LINE_INV:   begin launch = accept; launch_op = OP_INV;       end
      SEL_LINE_CLINV: begin launch = accept; launch_op = OP_CLEAN_INV; end
      SEL_CLEAN_END, SEL_INV_END: begin
        end_hit      = accept && pend_vld &&
                       (pend_inv == (reg_sel_e'(wr_sel) == SEL_INV_END));
        launch       = end_hit;
        launch_op    = pend_inv ? OP_INV : OP_CLEAN;
        launch_page  = pend_addr[ADDR_W-1:PAGE_W];
        launch_first = pend_first;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_inv  <= 1'b0;
      pend_addr <= '0;
    end else if (accept && (reg_sel_e'(wr_sel) == SEL_CLEAN_START ||
                            reg_sel_e'(wr_sel) == SEL_INV_START)) begin
      pend_vld  <= 1'b1;
      pend_inv  <= (reg_sel_e'(wr_sel) == SEL_INV_START);
      pend_addr <= wr_data;
    end else if (end_hit) begin
      pend_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/rme_walker.sv
module rme_walker
  import rme_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 5,
  parameter int PAGE_W = 12,
  localparam int IDX_W = PAGE_W - LINE_W,
  localparam int PG_W  = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  line_op_e          launch_op,
  input  logic [PG_W-1:0]   launch_page,
  input  logic [IDX_W:0]    launch_first,
  input  logic [IDX_W-1:0]  launch_last,
  input  logic              cmd_ready,
  output logic              busy,
  output logic              done,
  output logic              cmd_valid,
  output line_op_e          cmd_op,
  output logic [ADDR_W-1:0] cmd_addr
);
  logic [IDX_W-1:0] cur_idx;
  logic [IDX_W-1:0] last_idx;
  logic [PG_W-1:0]  page_q;
  line_op_e         op_q;
  logic             empty;

  assign empty = launch_first > {1'b0, launch_last};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      cur_idx  <= '0;
      last_idx <= '0;
      page_q   <= '0;
      op_q     <= OP_CLEAN;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (cmd_ready) begin
          if (cur_idx == last_idx) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            cur_idx <= cur_idx + 1'b1;
          end
        end
      end else if (launch) begin
        op_q     <= launch_op;
        page_q   <= launch_page;
        last_idx <= launch_last;
        if (empty) begin
          done <= 1'b1;
        end else begin
          busy    <= 1'b1;
          cur_idx <= launch_first[IDX_W-1:0];
        end
      end
    end
  end

  assign cmd_valid = busy;
  assign cmd_op    = op_q;
  assign cmd_addr  = {page_q, cur_idx, {LINE_W{1'b0}}};
endmodule

// File: rtl/range_maint_engine.sv
module range_maint_engine
  import rme_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096,
  localparam int LINE_W = $clog2(LINE_BYTES),
  localparam int PAGE_W = $clog2(PAGE_BYTES),
  localparam int IDX_W  = PAGE_W - LINE_W,
  localparam int PG_W   = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic              stall,
  output logic              done,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr
);
  logic             busy;
  logic             launch;
  line_op_e         launch_op;
  line_op_e         op_out;
  logic [PG_W-1:0]  launch_page;
  logic [IDX_W:0]   launch_first;
  logic [IDX_W-1:0] launch_last;

  rme_regcap #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .PAGE_W(PAGE_W)) u_regcap (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (reg_we),
    .wr_sel       (reg_sel),
    .wr_data      (reg_wdata),
    .busy         (busy),
    .launch       (launch),
    .launch_op    (launch_op),
    .launch_page  (launch_page),
    .launch_first (launch_first),
    .launch_last  (launch_last)
  );

  rme_walker #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .PAGE_W(PAGE_W)) u_walker (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch       (launch),
    .launch_op    (launch_op),
    .launch_page  (launch_page),
    .launch_first (launch_first),
    .launch_last  (launch_last),
    .cmd_ready    (cmd_ready),
    .busy         (busy),
    .done         (done),
    .cmd_valid    (cmd_valid),
    .cmd_op       (op_out),
    .cmd_addr     (cmd_addr)
  );

  assign stall  = busy;
  assign cmd_op = op_out;
endmodule

// File: rtl/rme_checker.sv
module rme_checker #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096,
  localparam int PAGE_W = $clog2(PAGE_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall,
  input logic              done,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr
);
  AST_HOLD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_op)); // R6

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid ||
      (cmd_addr == $past(cmd_addr) + ADDR_W'(LINE_BYTES) && $stable(cmd_op))); // R2

  AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid ||
      ((cmd_addr >> PAGE_W) == ($past(cmd_addr) >> PAGE_W))); // R10

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_valid) |-> done); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !stall); // R7
endmodule

bind range_maint_engine rme_checker #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .done(done),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr)
);

// File: tb/range_maint_engine_test.sv
module range_maint_engine_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd7;
  logic [31:0] reg_wdata = '0;
  logic        cmd_ready = 1'b0;
  logic        stall, done, cmd_valid;
  logic [1:0]  cmd_op;
  logic [31:0] cmd_addr;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  range_maint_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .stall(stall), .done(done), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr)
  );

  typedef struct packed {
    logic [2:0]  ssel;
    logic [31:0] sa;
    logic [2:0]  esel;
    logic [31:0] ea;
    logic [31:0] first;
    logic [8:0]  cnt;
    logic [1:0]  op;
    logic        mode;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{3'd3, 32'h1000, 3'd4, 32'h1060, 32'h1000, 9'd4,   2'd0, 1'b0}, // R2 aligned clean
    '{3'd5, 32'h2020, 3'd6, 32'h2020, 32'h2020, 9'd1,   2'd1, 1'b1}, // R3 single line inv
    '{3'd3, 32'h3005, 3'd4, 32'h307F, 32'h3020, 9'd3,   2'd0, 1'b1}, // R3 unaligned ends
    '{3'd5, 32'h4000, 3'd6, 32'h4FFF, 32'h4000, 9'd128, 2'd1, 1'b0}, // R2 whole page
    '{3'd3, 32'h5100, 3'd4, 32'h7140, 32'h5100, 9'd3,   2'd0, 1'b1}, // R10 foreign end page
    '{3'd5, 32'h6040, 3'd6, 32'h6020, 32'h0,    9'd0,   2'd1, 1'b0}, // R4 end below start
    '{3'd3, 32'h6021, 3'd4, 32'h603F, 32'h0,    9'd0,   2'd0, 1'b0}  // R4 rounds past end
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0; reg_sel = 3'd7;
  endtask

  // Called at the negedge right after the launching write.
  task automatic run_op(input logic [31:0] first, input int cnt, input logic [1:0] op,
                        input bit mode, input string req);
    int k = 0;
    bit seen = 0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      if (done) begin
        seen = 1;
        chk(!stall, "R7 stall low at done", 32'(stall), 32'd0);
        break;
      end
      if (cmd_valid) begin
        chk(cmd_addr == first + 32'(k * 32), req, cmd_addr, first + 32'(k * 32));
        chk(cmd_op == op, req, 32'(cmd_op), 32'(op));
        chk(stall, "R5 stall during walk", 32'(stall), 32'd1);
        cmd_ready = mode ? cyc[0] : 1'b1;
        if (cmd_ready) k++;
      end else begin
        cmd_ready = 1'b0;
      end
      @(negedge clk);
    end
    cmd_ready = 1'b0;
    chk(seen, "R7 done seen", 32'(seen), 32'd1);
    chk(k == cnt, req, 32'(k), 32'(cnt));
    @(negedge clk);
    chk(!done, "R7 done single cycle", 32'(done), 32'd0);
  endtask

  task automatic check_idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!cmd_valid && !done, req, {30'd0, cmd_valid, done}, 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!stall && !done && !cmd_valid, "R1 reset state", {29'd0, stall, done, cmd_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!stall && !done && !cmd_valid, "R1 after release", {29'd0, stall, done, cmd_valid}, 32'd0);

    foreach (VECS[i]) begin
      do_write(VECS[i].ssel, VECS[i].sa);
      do_write(VECS[i].esel, VECS[i].ea);
      run_op(VECS[i].first, int'(VECS[i].cnt), VECS[i].op, VECS[i].mode, "R2/R3/R4/R10 vector");
    end

    // R8: second start replaces the first
    do_write(3'd3, 32'h1000);
    do_write(3'd3, 32'h1100);
    do_write(3'd4, 32'h1120);
    run_op(32'h1100, 2, 2'd0, 1'b0, "R8 replaced start");

    // R9: end with nothing pending
    do_write(3'd4, 32'h1040);
    check_idle(4, "R9 orphan end");
    // R9: end of the other kind is ignored, pending kept
    do_write(3'd5, 32'h2000);
    do_write(3'd4, 32'h2040);
    check_idle(4, "R9 mismatched end");
    do_write(3'd6, 32'h2020);
    run_op(32'h2000, 2, 2'd1, 1'b1, "R9 pending kept");

    // R11: single-line commands
    do_write(3'd2, 32'h3047);
    run_op(32'h3040, 1, 2'd2, 1'b0, "R11 clean+inv line");
    do_write(3'd0, 32'h30FF);
    run_op(32'h30E0, 1, 2'd0, 1'b1, "R11 clean line");
    do_write(3'd1, 32'h7001);
    run_op(32'h7000, 1, 2'd1, 1'b0, "R11 inv line");

    // R12: writes during stall are dropped
    do_write(3'd3, 32'h1000);
    do_write(3'd4, 32'h1020);
    chk(stall, "R12 stalled", 32'(stall), 32'd1);
    do_write(3'd0, 32'h8000);
    do_write(3'd5, 32'h9000);
    do_write(3'd4, 32'h1000);
    chk(cmd_addr == 32'h1000, "R12 walk unchanged", cmd_addr, 32'h1000);
    run_op(32'h1000, 2, 2'd0, 1'b0, "R12 original walk");
    check_idle(4, "R12 no extra work");
    do_write(3'd6, 32'h9020);
    check_idle(3, "R12 start during stall dropped");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule